// File: doc/BRIEF.md
# Ring Receive Statistics Counters

This block keeps receive statistics for a token-ring style transceiver port. A frame parser, outside this block, sends single-cycle event strobes. They mark a start delimiter and whether its token bit is set, the end of the source address field, each data byte, the end delimiter, an error abort, and two kinds of discarded frame. The block counts frames, counts the data bytes that follow the source address, and counts the two kinds of discard.

A host reads the counters through one 16-bit read port with a select field and a read strobe. The read data is combinational from the select. A read's side effects take place at the clock edge where the strobe is high. The 32-bit byte counter is read in two accesses, high half first. The first access freezes the low half, so the two halves always form one snapshot. If any other read comes between the two accesses, the pair starts again. The two error counters are packed into one word. They clear themselves when that word is read.

The byte counter wraps to zero when it overflows.

Top module: `ring_rx_stats`

## Requirements
- R1: After reset, the reads at select 0 (frames), select 1 (bytes) and select 2 (errors) all return 0000H.
- R2: A start delimiter strobe with the token input high adds one to the frame count at select 0. A start delimiter with the token input low leaves the count unchanged.
- R3: The 16-bit frame count wraps from FFFFH to 0000H.
- R4: The source-address-done strobe sets the byte count to zero and enables counting. While counting is enabled, each data byte strobe adds one. Before that, data byte strobes are ignored.
- R5: An end delimiter strobe or an error abort strobe stops byte counting. A byte strobe in the same cycle as the stop, or any later byte strobe, is not counted.
- R6: The first read at select 1 returns byte count bits 31..16 and captures bits 15..0. The next read at select 1, with no other read between, returns the captured bits, even if bytes arrived after the capture.
- R7: A read at any other select between the two accesses makes the next select 1 read return the high half again, as a new first access.
- R8: The read at select 2 returns the duplicate discard count in bits 15..8 and the format-error discard count in bits 7..0. Each counter adds one per strobe on its input.
- R9: A read at select 2 clears both error counters to 00H.
- R10: Each error counter stops at FFH and does not wrap.
- R11: A discard strobe in the same cycle as the clearing read leaves that counter at 01H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_i | input | 1 | Start delimiter seen |
| token_i | input | 1 | Token bit condition, qualifies sd_i |
| sa_done_i | input | 1 | Source address field complete |
| byte_i | input | 1 | One data byte received |
| ed_i | input | 1 | End delimiter seen |
| abort_i | input | 1 | Start delimiter in an error situation |
| dup_drop_i | input | 1 | Frame discarded for a duplicate |
| fmt_drop_i | input | 1 | Frame discarded for a format error |
| rd_i | input | 1 | Host read strobe |
| sel_i | input | 2 | Register select: 0 frames, 1 bytes, 2 errors |
| rdata_o | output | 16 | Read data for the selected register |

## Verification
Frame strobes are applied with and without the token qualifier, which shows whether the qualifier gates the count. Byte strobes are placed before the source-address-done strobe, between it and a stop, on the stop cycle, and after the stop, which separates the counting window from its edges. Data-counter reads are given back to back, with a foreign read between them, and with bytes arriving between them. These cases separate a captured snapshot from a live low half, and a restarted pair from a continued one. The error word is read after single strobes, after a long run of strobes that reaches saturation, and on a cycle that also carries a discard strobe.

// File: rtl/ring_rx_stats.sv
module ring_rx_stats #(
  parameter int FRM_W = 16,
  parameter int ERR_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sd_i,
  input  logic        token_i,
  input  logic        sa_done_i,
  input  logic        byte_i,
  input  logic        ed_i,
  input  logic        abort_i,
  input  logic        dup_drop_i,
  input  logic        fmt_drop_i,
  input  logic        rd_i,
  input  logic [1:0]  sel_i,
  output logic [15:0] rdata_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [FRM_W-1:0] frm_cnt;
  logic [31:0]      byte_cnt;
  logic [15:0]      lo_hold;
  logic             cnt_en;
  logic             hi_pend;
  logic [ERR_W-1:0] dup_cnt;
  logic [ERR_W-1:0] fmt_cnt;

  wire rd_data = rd_i && (sel_i == 2'd1);
  wire rd_err  = rd_i && (sel_i == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) frm_cnt <= '0;
    else if (sd_i && token_i) frm_cnt <= frm_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt <= '0;
      cnt_en   <= 1'b0;
    end else if (sa_done_i) begin
      byte_cnt <= '0;
      cnt_en   <= 1'b1;
    end else if (ed_i || abort_i) begin
      cnt_en   <= 1'b0;
    end else if (byte_i && cnt_en) begin
      byte_cnt <= byte_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_pend <= 1'b0;
      lo_hold <= '0;
    end else if (rd_data) begin
      hi_pend <= !hi_pend;
      if (!hi_pend) lo_hold <= byte_cnt[15:0];
    end else if (rd_i) begin
      hi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dup_cnt <= '0;
      fmt_cnt <= '0;
    end else if (rd_err) begin
      dup_cnt <= ERR_W'(dup_drop_i);
      fmt_cnt <= ERR_W'(fmt_drop_i);
    end else begin
      if (dup_drop_i && dup_cnt != ERR_MAX) dup_cnt <= dup_cnt + 1'b1;
      if (fmt_drop_i && fmt_cnt != ERR_MAX) fmt_cnt <= fmt_cnt + 1'b1;
    end
  end

  always_comb begin
    case (sel_i)
      2'd0:    rdata_o = 16'(frm_cnt);
      2'd1:    rdata_o = hi_pend ? lo_hold : byte_cnt[31:16];
      2'd2:    rdata_o = 16'({dup_cnt, fmt_cnt});
      default: rdata_o = '0;
    endcase
  end
endmodule

module ring_rx_stats_chk #(
  parameter int FRM_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sd_i,
  input logic             token_i,
  input logic             sa_done_i,
  input logic             rd_i,
  input logic [1:0]       sel_i,
  input logic             dup_drop_i,
  input logic [FRM_W-1:0] frm_cnt,
  input logic [31:0]      byte_cnt,
  input logic             cnt_en,
  input logic             hi_pend,
  input logic [ERR_W-1:0] dup_cnt
);
  // R2
  frm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_i && token_i) |=> frm_cnt == $past(frm_cnt) + 1'b1);
  // R2
  frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sd_i && token_i) |=> $stable(frm_cnt));
  // R5
  byte_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sa_done_i) |=> $stable(byte_cnt));
  // R6
  pair_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i == 2'd1 && hi_pend) |=> !hi_pend);
  // R7
  pair_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i != 2'd1) |=> !hi_pend);
  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sel_i == 2'd2 && !dup_drop_i) |=> dup_cnt == '0);
  // R10
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_cnt == '1 && !(rd_i && sel_i == 2'd2)) |=> dup_cnt == '1);
endmodule

bind ring_rx_stats ring_rx_stats_chk #(.FRM_W(FRM_W), .ERR_W(ERR_W)) chk (
  .clk(clk), .rst_n(rst_n), .sd_i(sd_i), .token_i(token_i),
  .sa_done_i(sa_done_i), .rd_i(rd_i), .sel_i(sel_i),
  .dup_drop_i(dup_drop_i), .frm_cnt(frm_cnt), .byte_cnt(byte_cnt),
  .cnt_en(cnt_en), .hi_pend(hi_pend), .dup_cnt(dup_cnt)
);

// File: tb/ring_rx_stats_test.sv
module ring_rx_stats_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd_i = 0, token_i = 0, sa_done_i = 0, byte_i = 0, ed_i = 0, abort_i = 0;
  logic dup_drop_i = 0, fmt_drop_i = 0, rd_i = 0;
  logic [1:0]  sel_i = 0;
  logic [15:0] rdata_o;
  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  ring_rx_stats uut (
    .clk(clk), .rst_n(rst_n), .sd_i(sd_i), .token_i(token_i),
    .sa_done_i(sa_done_i), .byte_i(byte_i), .ed_i(ed_i), .abort_i(abort_i),
    .dup_drop_i(dup_drop_i), .fmt_drop_i(fmt_drop_i), .rd_i(rd_i),
    .sel_i(sel_i), .rdata_o(rdata_o)
  );

  // {req, sd, tok, sa, byte, ed, abort, dup, fmt, rd, sel[1:0], expected}
  localparam int NV = 24;
  localparam logic [30:0] VEC [NV] = '{
    {4'd2,  11'b11000000000, 16'h0000},  // R2 frame with token
    {4'd2,  11'b10000000000, 16'h0001},  // R2 no token
    {4'd2,  11'b00000000000, 16'h0001},  // R2
    {4'd4,  11'b00010000001, 16'h0000},  // R4 byte before window
    {4'd4,  11'b00100000001, 16'h0000},  // R4 open window
    {4'd4,  11'b00010000001, 16'h0000},  // R4
    {4'd4,  11'b00010000001, 16'h0000},  // R4
    {4'd5,  11'b00011000001, 16'h0000},  // R5 byte with stop
    {4'd5,  11'b00010000001, 16'h0000},  // R5 byte after stop
    {4'd6,  11'b00000000101, 16'h0000},  // R6 first access
    {4'd6,  11'b00000000101, 16'h0002},  // R6 second access
    {4'd8,  11'b00000011010, 16'h0000},  // R8
    {4'd8,  11'b00000010010, 16'h0101},  // R8
    {4'd8,  11'b00000001010, 16'h0201},  // R8
    {4'd9,  11'b00000000110, 16'h0202},  // R9 clearing read
    {4'd9,  11'b00000000010, 16'h0000},  // R9
    {4'd4,  11'b00100000001, 16'h0000},  // R4 new frame data
    {4'd4,  11'b00010000001, 16'h0000},  // R4
    {4'd5,  11'b00000100001, 16'h0000},  // R5 abort
    {4'd5,  11'b00010000001, 16'h0000},  // R5
    {4'd7,  11'b00000000101, 16'h0000},  // R7 first access
    {4'd7,  11'b00000000100, 16'h0001},  // R7 foreign read
    {4'd7,  11'b00000000101, 16'h0000},  // R7 restarts high
    {4'd7,  11'b00000000101, 16'h0001}   // R7 low half
  };

  task automatic check(input string req, input logic [15:0] exp);
    tests++;
    if (rdata_o !== exp) begin
      fails++;
      $display("FAIL %s: rdata %h expected %h", req, rdata_o, exp);
    end
  endtask

  task automatic idle();
    {sd_i, token_i, sa_done_i, byte_i, ed_i, abort_i, dup_drop_i, fmt_drop_i, rd_i} = '0;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      tests++; fails++;
      $display("FAIL watchdog: cycle %0d expected below 190000", cyc);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 3; s++) begin
      sel_i = s[1:0]; #1; check("R1", 16'h0000);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {sd_i, token_i, sa_done_i, byte_i, ed_i, abort_i,
       dup_drop_i, fmt_drop_i, rd_i, sel_i} = VEC[i][26:16];
      #1;
      check($sformatf("R%0d", VEC[i][30:27]), VEC[i][15:0]);
    end
    @(negedge clk); idle();

    // R3 wrap: frame count is 1 here
    sd_i = 1; token_i = 1; sel_i = 0;
    repeat (65534) @(negedge clk);
    idle(); #1; check("R3", 16'hFFFF);
    sd_i = 1; token_i = 1;
    @(negedge clk); idle(); #1; check("R3", 16'h0000);

    // R6 snapshot with a nonzero high half
    sa_done_i = 1; @(negedge clk); idle();
    byte_i = 1; repeat (70000) @(negedge clk); idle();
    sel_i = 1; rd_i = 1; #1; check("R6", 16'h0001);
    @(negedge clk); idle();
    byte_i = 1; repeat (5) @(negedge clk); idle();
    rd_i = 1; #1; check("R6", 16'h1170);
    @(negedge clk); idle(); #1; check("R6", 16'h0001);

    // R10 saturation
    sel_i = 2; rd_i = 1; @(negedge clk); idle();
    dup_drop_i = 1; repeat (300) @(negedge clk); idle();
    #1; check("R10", 16'hFF00);
    // R11 strobe during clearing read
    rd_i = 1; dup_drop_i = 1; #1; check("R11", 16'hFF00);
    @(negedge clk); idle(); #1; check("R11", 16'h0100);

    report();
  end
endmodule